// File: doc/BRIEF.md
# Fixed-Frame Host Command Parser

This block sits behind a UART receiver and turns its stream of bytes into checked commands. Every host command is a 5-byte frame: an identifier, two argument bytes (an address sent high byte first, or payload), a checksum equal to the 8-bit sum of the two argument bytes, and finally the identifier sent again. When the fifth byte has arrived, the parser judges the frame. A good frame raises exactly one class strobe. The command identifier and the 16-bit argument are shown on the field outputs while that strobe is high. A bad frame raises a NAK request instead, and the reply framer answers it with its fixed negative-acknowledge frame.

The read strobe serves as the reply request to the framer. That framer decodes the size (byte or word) and the space (RAM or ROM) from the identifier. Identifier 0x81 is not a 5-byte frame. It opens a bulk transfer: the next byte is a length N, and the N bytes that follow are passed one by one to the bulk write engine. If the stream goes quiet part-way through a frame or a bulk transfer for `TIMEOUT_CYC` cycles, the parser drops what it has collected and treats the next byte as a fresh identifier.

The receive machine has seven named states:
- IDLE waits for an identifier. A byte of 0x81 takes it to BLEN. Any other byte takes it to B2.
- B2, B3, B4 and B5 each wait for the next byte and move to the following state. The byte accepted in B5 completes the frame and returns the machine to IDLE.
- BLEN accepts the length. A length of 0 returns to IDLE. Any other length goes to BDATA.
- BDATA accepts one data byte per transition and returns to IDLE after the last one.
- From any state other than IDLE, a timeout returns the machine to IDLE.

Top module: `cmd_frame_parser`

## Requirements
- R1: While reset is held and on the first cycle after it, every strobe output (rd_stb, stage_stb, dest_stb, bulk_addr_stb, nak_stb, bulk_valid, bulk_last) is low.
- R2: The judgement of a frame appears on the cycle after the clock edge that accepts its fifth byte, as a single-cycle pulse. While that pulse is high, cmd_id holds byte 1 and cmd_arg holds {byte 2, byte 3}.
- R3: A frame is good only when byte 5 equals byte 1 and byte 4 equals (byte 2 + byte 3) mod 256.
- R4: The supported identifiers are 0x02–0x05, 0x10, 0x11, 0x20–0x23 and 0x80. A complete 5-byte frame with any other identifier is bad.
- R5: A good frame with identifier 0x02, 0x03, 0x04 or 0x05 raises rd_stb (a read-reply request). cmd_arg then carries the address, high byte first.
- R6: A good frame with identifier 0x10 or 0x11 raises stage_stb. A 0x10 frame is good only when byte 3 is the bitwise inverse of byte 2.
- R7: A good frame with identifier 0x20–0x23 raises dest_stb. A good frame with identifier 0x80 raises bulk_addr_stb.
- R8: A bad frame raises nak_stb for one cycle and no other strobe. At most one strobe of the five is ever high.
- R9: An identifier byte of 0x81 is followed by a length byte N. Each of the next N accepted bytes appears on bulk_data with bulk_valid on the cycle after it is accepted, and bulk_last marks the Nth. None of these bytes raises a frame strobe. N = 0 returns the parser straight to waiting for an identifier.
- R10: If TIMEOUT_CYC consecutive clock edges pass with no byte while a frame or bulk transfer is incomplete, the partial data is dropped silently and the next byte is taken as byte 1.
- R11: Gaps of up to TIMEOUT_CYC−1 idle cycles between the bytes of a frame do not disturb it.
- R12: rx_data is ignored on every cycle in which rx_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| cmd_id | output | 8 | Identifier of the judged frame, valid with a strobe |
| cmd_arg | output | 16 | {byte 2, byte 3} of the judged frame, valid with a strobe |
| rd_stb | output | 1 | Good read command: read-reply request |
| stage_stb | output | 1 | Good byte/word staging command |
| dest_stb | output | 1 | Good destination (commit) command |
| bulk_addr_stb | output | 1 | Good bulk-address command |
| nak_stb | output | 1 | Bad frame: request for a NAK reply |
| bulk_valid | output | 1 | A bulk data byte is on bulk_data |
| bulk_data | output | 8 | Bulk data byte |
| bulk_last | output | 1 | Final byte of the bulk transfer |

## Verification
The hardest situation to reach is a timeout that fires on the exact boundary. A gap of TIMEOUT_CYC−1 idle cycles must keep the frame, and one more idle cycle must drop it. This has to hold both inside a 5-byte frame and inside a bulk transfer. The stimulus controls byte spacing by cycle count and places gaps of exactly those two lengths at different byte positions. After each gap it sends a complete frame, so a missed resynchronisation shows up as a wrong or missing strobe. A bulk payload that contains identifier-like bytes (0x02, 0x81) also checks that bulk bytes never reach the frame path.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_B2, ST_B3, ST_B4, ST_B5, ST_BLEN, ST_BDATA
    } rx_state_t;

    typedef enum logic [2:0] {
        CL_NONE, CL_READ, CL_STAGE, CL_DEST, CL_BADDR
    } cmd_class_t;

    localparam logic [7:0] ID_BULK_DATA  = 8'h81;
    localparam logic [7:0] ID_BULK_ADDR  = 8'h80;
    localparam logic [7:0] ID_BYTE_STAGE = 8'h10;
    localparam logic [7:0] ID_WORD_STAGE = 8'h11;

    function automatic cmd_class_t classify(input logic [7:0] id);
        if (id >= 8'h02 && id <= 8'h05)                return CL_READ;
        if (id == ID_BYTE_STAGE || id == ID_WORD_STAGE) return CL_STAGE;
        if (id >= 8'h20 && id <= 8'h23)                return CL_DEST;
        if (id == ID_BULK_ADDR)                        return CL_BADDR;
        return CL_NONE;
    endfunction

endpackage

// File: rtl/cfp_idle_timer.sv
module cfp_idle_timer #(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic rx_valid,
    output logic expire
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !armed || rx_valid || expire) cnt_q <= '0;
        else                                         cnt_q <= cnt_q + 1'b1;
    end

    assign expire = armed && !rx_valid && (cnt_q == LAST);

    // R10
    timeout_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !armed);

endmodule

// File: rtl/cfp_collector.sv
module cfp_collector
    import cfp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       expire,
    output logic       armed,
    output logic       frame_done,
    output logic [7:0] f_id,
    output logic [7:0] f_b2,
    output logic [7:0] f_b3,
    output logic [7:0] f_b4,
    output logic [7:0] f_b5,
    output logic       bulk_valid,
    output logic [7:0] bulk_data,
    output logic       bulk_last
);
    rx_state_t state_q, state_d;
    logic [7:0] rem_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (expire) begin
            state_d = ST_IDLE;
        end else if (rx_valid) begin
            unique case (state_q)
                ST_IDLE:  state_d = (rx_data == ID_BULK_DATA) ? ST_BLEN : ST_B2;
                ST_B2:    state_d = ST_B3;
                ST_B3:    state_d = ST_B4;
                ST_B4:    state_d = ST_B5;
                ST_B5:    state_d = ST_IDLE;
                ST_BLEN:  state_d = (rx_data == 8'h00) ? ST_IDLE : ST_BDATA;
                ST_BDATA: state_d = (rem_q == 8'h01) ? ST_IDLE : ST_BDATA;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    assign armed = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done <= 1'b0;
            bulk_valid <= 1'b0;
            bulk_last  <= 1'b0;
            bulk_data  <= '0;
            rem_q      <= '0;
            f_id <= '0; f_b2 <= '0; f_b3 <= '0; f_b4 <= '0; f_b5 <= '0;
        end else begin
            frame_done <= 1'b0;
            bulk_valid <= 1'b0;
            bulk_last  <= 1'b0;
            if (rx_valid) begin
                unique case (state_q)
                    ST_IDLE: f_id <= rx_data;
                    ST_B2:   f_b2 <= rx_data;
                    ST_B3:   f_b3 <= rx_data;
                    ST_B4:   f_b4 <= rx_data;
                    ST_B5: begin
                        f_b5       <= rx_data;
                        frame_done <= 1'b1;
                    end
                    ST_BLEN: rem_q <= rx_data;
                    ST_BDATA: begin
                        bulk_valid <= 1'b1;
                        bulk_data  <= rx_data;
                        bulk_last  <= (rem_q == 8'h01);
                        rem_q      <= rem_q - 8'h01;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    done_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(rx_valid));

    // R9
    bulk_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_valid |-> ($past(rx_valid) && bulk_data == $past(rx_data)));

endmodule

// File: rtl/cfp_checker.sv
module cfp_checker
    import cfp_pkg::*;
(
    input  logic       frame_done,
    input  logic [7:0] f_id,
    input  logic [7:0] f_b2,
    input  logic [7:0] f_b3,
    input  logic [7:0] f_b4,
    input  logic [7:0] f_b5,
    output logic       rd_stb,
    output logic       stage_stb,
    output logic       dest_stb,
    output logic       bulk_addr_stb,
    output logic       nak_stb
);
    cmd_class_t kind;
    logic [7:0] sum;
    logic       good;

    always_comb begin
        kind = classify(f_id);
        sum  = f_b2 + f_b3;
        good = frame_done
            && (f_b5 == f_id)
            && (f_b4 == sum)
            && ((f_id != ID_BYTE_STAGE) || (f_b3 == ~f_b2))
            && (kind != CL_NONE);
        rd_stb        = good && (kind == CL_READ);
        stage_stb     = good && (kind == CL_STAGE);
        dest_stb      = good && (kind == CL_DEST);
        bulk_addr_stb = good && (kind == CL_BADDR);
        nak_stb       = frame_done && !good;
    end

endmodule

// File: rtl/cmd_frame_parser.sv
module cmd_frame_parser #(
    parameter int TIMEOUT_CYC = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic [7:0]  cmd_id,
    output logic [15:0] cmd_arg,
    output logic        rd_stb,
    output logic        stage_stb,
    output logic        dest_stb,
    output logic        bulk_addr_stb,
    output logic        nak_stb,
    output logic        bulk_valid,
    output logic [7:0]  bulk_data,
    output logic        bulk_last
);
    logic armed, expire, frame_done;
    logic [7:0] f_id, f_b2, f_b3, f_b4, f_b5;

    cfp_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .armed(armed), .rx_valid(rx_valid), .expire(expire)
    );

    cfp_collector u_coll (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .expire(expire), .armed(armed), .frame_done(frame_done),
        .f_id(f_id), .f_b2(f_b2), .f_b3(f_b3), .f_b4(f_b4), .f_b5(f_b5),
        .bulk_valid(bulk_valid), .bulk_data(bulk_data), .bulk_last(bulk_last)
    );

    cfp_checker u_chk (
        .frame_done(frame_done), .f_id(f_id), .f_b2(f_b2), .f_b3(f_b3),
        .f_b4(f_b4), .f_b5(f_b5), .rd_stb(rd_stb), .stage_stb(stage_stb),
        .dest_stb(dest_stb), .bulk_addr_stb(bulk_addr_stb), .nak_stb(nak_stb)
    );

    assign cmd_id  = f_id;
    assign cmd_arg = {f_b2, f_b3};

    // R3
    trailer_repeats_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || stage_stb || dest_stb || bulk_addr_stb) |-> (cmd_id == $past(rx_data)));

    // R8
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_stb, stage_stb, dest_stb, bulk_addr_stb, nak_stb}));

    // R9
    bulk_no_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_valid |-> !(rd_stb || stage_stb || dest_stb || bulk_addr_stb || nak_stb));

endmodule

// File: tb/cmd_frame_parser_tb.sv
module cmd_frame_parser_tb;
    localparam int T = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic [7:0]  cmd_id, bulk_data;
    logic [15:0] cmd_arg;
    logic        rd_stb, stage_stb, dest_stb, bulk_addr_stb, nak_stb, bulk_valid, bulk_last;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    logic [7:0] junk = 8'h3C;

    always #10 clk = ~clk;

    cmd_frame_parser #(.TIMEOUT_CYC(T)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .cmd_id(cmd_id), .cmd_arg(cmd_arg), .rd_stb(rd_stb), .stage_stb(stage_stb),
        .dest_stb(dest_stb), .bulk_addr_stb(bulk_addr_stb), .nak_stb(nak_stb),
        .bulk_valid(bulk_valid), .bulk_data(bulk_data), .bulk_last(bulk_last)
    );

    // Behavioural reference model
    logic [7:0] fq[$];
    int mode = 0;      // 0 frame, 1 expect length, 2 bulk data
    int remaining = 0;
    int gap = 0;
    logic e_rd, e_st, e_de, e_ba, e_nak, e_bv, e_bl;
    logic [7:0]  e_id, e_bd;
    logic [15:0] e_arg;

    always @(posedge clk) begin
        e_rd = 0; e_st = 0; e_de = 0; e_ba = 0; e_nak = 0; e_bv = 0; e_bl = 0;
        if (!rst_n) begin
            fq.delete(); mode = 0; remaining = 0; gap = 0;
        end else if (rx_valid) begin
            gap = 0;
            if (mode == 0) begin
                fq.push_back(rx_data);
                if (fq.size() == 1 && rx_data == 8'h81) begin
                    fq.delete(); mode = 1;
                end else if (fq.size() == 5) begin
                    logic ok;
                    logic [7:0] id;
                    id = fq[0];
                    ok = (fq[4] == id) && (fq[3] == 8'(fq[1] + fq[2]));
                    if (id == 8'h10 && fq[2] != ~fq[1]) ok = 0;
                    e_id = id; e_arg = {fq[1], fq[2]};
                    if (ok && id >= 8'h02 && id <= 8'h05)      e_rd = 1;
                    else if (ok && (id == 8'h10 || id == 8'h11)) e_st = 1;
                    else if (ok && id >= 8'h20 && id <= 8'h23) e_de = 1;
                    else if (ok && id == 8'h80)                e_ba = 1;
                    else                                       e_nak = 1;
                    fq.delete();
                end
            end else if (mode == 1) begin
                remaining = rx_data;
                mode = (rx_data == 0) ? 0 : 2;
            end else begin
                e_bv = 1; e_bd = rx_data;
                remaining--;
                e_bl = (remaining == 0);
                if (remaining == 0) mode = 0;
            end
        end else if (mode != 0 || fq.size() != 0) begin
            gap++;
            if (gap == T) begin
                fq.delete(); mode = 0; gap = 0;
            end
        end else begin
            gap = 0;
        end
    end

    task automatic cmp(string sig, string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s/%s %s actual=%h expected=%h t=%0t", tag, cur_req, sig, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            cmp("strobes", "R1", 16'({rd_stb, stage_stb, dest_stb, bulk_addr_stb, nak_stb, bulk_valid, bulk_last}), 16'h0);
        end else begin
            cmp("rd_stb", "R5", 16'(rd_stb), 16'(e_rd));
            cmp("stage_stb", "R6", 16'(stage_stb), 16'(e_st));
            cmp("dest_stb", "R7", 16'(dest_stb), 16'(e_de));
            cmp("bulk_addr_stb", "R7", 16'(bulk_addr_stb), 16'(e_ba));
            cmp("nak_stb", "R8", 16'(nak_stb), 16'(e_nak));
            cmp("bulk_valid", "R9", 16'(bulk_valid), 16'(e_bv));
            if (e_bv) begin
                cmp("bulk_data", "R9", 16'(bulk_data), 16'(e_bd));
                cmp("bulk_last", "R9", 16'(bulk_last), 16'(e_bl));
            end
            if (e_rd || e_st || e_de || e_ba) begin
                cmp("cmd_id", "R2", 16'(cmd_id), 16'(e_id));
                cmp("cmd_arg", "R2", cmd_arg, e_arg);
            end
        end
    end

    task automatic send_byte(logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_data  = b;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_valid = 1'b0;
            junk     = junk * 8'd5 + 8'd17;
            rx_data  = junk;   // R12: noise while rx_valid is low
        end
    endtask

    task automatic frame(logic [7:0] id, logic [7:0] a, logic [7:0] b,
                         logic [7:0] cs, logic [7:0] tr, int g);
        send_byte(id); if (g > 0) idle(g);
        send_byte(a);  if (g > 0) idle(g);
        send_byte(b);  if (g > 0) idle(g);
        send_byte(cs); if (g > 0) idle(g);
        send_byte(tr);
        idle(3);
    endtask

    task automatic good(logic [7:0] id, logic [7:0] a, logic [7:0] b);
        frame(id, a, b, 8'(a + b), id, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        @(negedge clk); rst_n = 1'b1;
        cur_req = "R1"; idle(2);

        cur_req = "R5";
        good(8'h02, 8'h12, 8'h34);
        good(8'h03, 8'hFF, 8'h01);
        good(8'h04, 8'h80, 8'h90);
        good(8'h05, 8'h00, 8'h00);

        cur_req = "R6";
        good(8'h10, 8'h5A, 8'hA5);
        good(8'h11, 8'h01, 8'h02);
        frame(8'h10, 8'h5A, 8'hA4, 8'hFE, 8'h10, 0);   // inverse mismatch -> NAK
        good(8'h10, 8'h00, 8'hFF);

        cur_req = "R7";
        for (int i = 8'h20; i <= 8'h23; i++) good(8'(i), 8'hC0, 8'h15);
        good(8'h80, 8'h12, 8'h34);

        cur_req = "R3";
        frame(8'h02, 8'h12, 8'h34, 8'h47, 8'h02, 0);  // checksum off by one
        frame(8'h03, 8'h12, 8'h34, 8'h46, 8'h04, 0);  // trailer differs
        frame(8'h21, 8'hF0, 8'h20, 8'h10, 8'h21, 0);  // wrapped sum is good

        cur_req = "R4";
        good(8'h00, 8'h01, 8'h01);
        good(8'h06, 8'h01, 8'h01);
        good(8'h7F, 8'h01, 8'h01);
        good(8'hFF, 8'h00, 8'hFF);
        good(8'h24, 8'h01, 8'h01);
        good(8'hA0, 8'h01, 8'h01);

        cur_req = "R8";
        good(8'h01, 8'h02, 8'h03);
        good(8'h02, 8'h02, 8'h03);

        cur_req = "R9";
        send_byte(8'h81); send_byte(8'h04);
        send_byte(8'h02); send_byte(8'h81); idle(2); send_byte(8'hBB); send_byte(8'hCC);
        idle(2);
        send_byte(8'h81); send_byte(8'h00); idle(1);
        good(8'h04, 8'hAB, 8'hCD);
        send_byte(8'h81); send_byte(8'h01); send_byte(8'h55); idle(2);

        cur_req = "R10";
        send_byte(8'h02); send_byte(8'h12); idle(T);
        good(8'h03, 8'h10, 8'h20);
        send_byte(8'h02); send_byte(8'h12); send_byte(8'h34); send_byte(8'h46); idle(T);
        good(8'h05, 8'h01, 8'h01);
        send_byte(8'h81); send_byte(8'h05); send_byte(8'h11); idle(T);
        good(8'h22, 8'h40, 8'h00);

        cur_req = "R11";
        frame(8'h02, 8'h33, 8'h44, 8'h77, 8'h02, T - 1);
        send_byte(8'h81); send_byte(8'h02); idle(T - 1); send_byte(8'h66); idle(T - 1);
        send_byte(8'h67); idle(2);

        cur_req = "R12";
        idle(40);
        good(8'h11, 8'hEE, 8'h11);

        idle(5);
        disable watchdog;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule